// File: doc/BRIEF.md
# Flag-preserving variable shift unit

This execution unit performs one of three register shifts: shift left with zero fill, shift right with zero fill, and shift right with sign fill. The shift amount comes from a second register operand. The mandatory-prefix code of the instruction picks the operation. The W bit and the current processor mode together pick the operand width, and the width in turn fixes how many count bits are used. No status flag is read or written.

Decode hands the unit an issue strobe together with the prefix code, the W and L bits, the processor mode and the two operands. Exactly one clock later the unit returns either a result with a result-valid strobe, or an invalid-opcode fault strobe. A fault is raised for a non-zero L bit, for real mode or virtual-8086 mode, and for a prefix code that selects none of the three shifts.

Top module: `flagless_shifter`

## Requirements
- R1: The prefix code `prefixSel` selects the operation: 2'b01 shifts left, 2'b10 shifts right with sign fill, and 2'b11 shifts right with zero fill.
- R2: When `wBit` is 1 and `cpuMode` is 2'b11 (64-bit mode), the operation is 64 bits wide and only count bits [5:0] are used.
- R3: In every other accepted case the operation is 32 bits wide on operand bits [31:0] and only count bits [4:0] are used. This includes `wBit`=1 in protected mode (2'b10).
- R4: A 32-bit operation returns its result zero-extended, so bits [63:32] of `result` are 0.
- R5: The sign-fill right shift copies the operand's top bit into every vacated position. The top bit is bit 31 or bit 63, depending on the operand width. A negative operand therefore rounds toward negative infinity.
- R6: The left shift and the zero-fill right shift put zeros into every vacated position.
- R7: A used count of zero returns the operand unchanged. For a 32-bit operation this is operand bits [31:0], zero-extended.
- R8: An issue with `lBit`=1 raises `faultOut` and gives no result.
- R9: An issue in real mode (2'b00) or virtual-8086 mode (2'b01) raises `faultOut` and gives no result. Protected mode (2'b10) and 64-bit mode are accepted.
- R10: An issue with prefix code 2'b00 (no prefix) raises `faultOut` and gives no result.
- R11: `resultValid` or `faultOut` rises exactly one cycle after an issue, and never both at once. With no issue, both stay low. `result` is 0 in every cycle in which `resultValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Issue strobe |
| prefixSel | input | 2 | Mandatory-prefix code |
| wBit | input | 1 | Width-select bit |
| lBit | input | 1 | Vector-length bit, must be 0 |
| cpuMode | input | 2 | 00 real, 01 virtual-8086, 10 protected, 11 64-bit |
| operand | input | 64 | Value to be shifted |
| count | input | 64 | Shift-count operand |
| result | output | 64 | Registered shift result |
| resultValid | output | 1 | Result strobe |
| faultOut | output | 1 | Invalid-opcode fault strobe |

## Verification
The bench builds the unit with its default 64-bit data width. At that width a single run reaches both the full-width path and the half-width path: the 6-bit and 5-bit count masks, counts above the mask, and sign fill from bit 63 and from bit 31. Directed counts of 0, 31, 33, 63 and 67 sit on the masking boundaries. Random issues then mix all four modes, all prefix codes, both W values and occasional L faults, and every cycle is compared against a bench model that shifts one bit per loop step.

// File: rtl/fshift_pkg.sv
`timescale 1ns/1ps
package fshift_pkg;
  typedef enum logic [1:0] {
    SEL_NONE  = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_ARITH = 2'b10,
    SEL_LOGIC = 2'b11
  } prefixSel_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'b00,
    MODE_V86  = 2'b01,
    MODE_PROT = 2'b10,
    MODE_LONG = 2'b11
  } cpuMode_e;

  typedef enum logic [1:0] {
    OP_SHL = 2'b00,
    OP_SHR = 2'b01,
    OP_SAR = 2'b10
  } shiftOp_e;

  typedef struct packed {
    logic     fire;
    logic     fault;
    logic     wide;
    shiftOp_e op;
  } shiftCtl_t;
endpackage

// File: rtl/fshift_ctrl.sv
`timescale 1ns/1ps
module fshift_ctrl
  import fshift_pkg::*;
(
  input  logic      inValid,
  input  logic [1:0] prefixSel,
  input  logic      wBit,
  input  logic      lBit,
  input  logic [1:0] cpuMode,
  output shiftCtl_t ctl
);
  logic modeOk;
  logic prefixOk;
  logic legal;

  assign modeOk   = (cpuMode == MODE_PROT) || (cpuMode == MODE_LONG);
  assign prefixOk = (prefixSel != SEL_NONE);
  assign legal    = modeOk && prefixOk && !lBit;

  always_comb begin
    ctl.fire  = inValid && legal;
    ctl.fault = inValid && !legal;
    ctl.wide  = wBit && (cpuMode == MODE_LONG);
    unique case (prefixSel)
      SEL_LEFT:  ctl.op = OP_SHL;
      SEL_ARITH: ctl.op = OP_SAR;
      SEL_LOGIC: ctl.op = OP_SHR;
      default:   ctl.op = OP_SHL;
    endcase
  end

  always_comb begin
    if (inValid && (cpuMode == MODE_REAL || cpuMode == MODE_V86))
      AST_LEGACY_MODE_FAULTS: assert (ctl.fault && !ctl.fire); // R9
  end
endmodule

// File: rtl/fshift_core.sv
`timescale 1ns/1ps
module fshift_core
  import fshift_pkg::*;
#(
  parameter int WIDTH = 64,
  localparam int CNT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] src,
  input  logic [CNT_W-1:0] amount,
  input  shiftOp_e         op,
  output logic [WIDTH-1:0] dst
);
  always_comb begin
    unique case (op)
      OP_SHL:  dst = src << amount;
      OP_SHR:  dst = src >> amount;
      OP_SAR:  dst = $unsigned($signed(src) >>> amount);
      default: dst = src << amount;
    endcase
  end
endmodule

// File: rtl/fshift_dp.sv
`timescale 1ns/1ps
module fshift_dp
  import fshift_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int NARROW_W = DATA_W / 2,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  shiftCtl_t         ctl,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  shiftAmt,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              faultOut
);
  logic [DATA_W-1:0]   wideOut;
  logic [NARROW_W-1:0] narrowOut;
  logic [DATA_W-1:0]   nextResult;

  fshift_core #(.WIDTH(DATA_W)) u_wideCore (
    .src(operand), .amount(shiftAmt), .op(ctl.op), .dst(wideOut)
  );

  fshift_core #(.WIDTH(NARROW_W)) u_narrowCore (
    .src(operand[NARROW_W-1:0]), .amount(shiftAmt[CNT_W-2:0]),
    .op(ctl.op), .dst(narrowOut)
  );

  assign nextResult = ctl.wide ? wideOut
                               : {{(DATA_W-NARROW_W){1'b0}}, narrowOut};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      faultOut    <= 1'b0;
    end else begin
      result      <= ctl.fire ? nextResult : '0;
      resultValid <= ctl.fire;
      faultOut    <= ctl.fault;
    end
  end

  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(resultValid && faultOut)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.fire && !ctl.fault) |=> (!resultValid && !faultOut && result == '0)); // R11
  AST_FAULT_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fault |=> (faultOut && !resultValid && result == '0)); // R8
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && !ctl.wide) |=> (result[DATA_W-1:NARROW_W] == '0)); // R4
  AST_ZERO_COUNT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fire && ctl.wide && shiftAmt == '0) |=> (result == $past(operand))); // R7
endmodule

// File: rtl/flagless_shifter.sv
`timescale 1ns/1ps
module flagless_shifter
  import fshift_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        prefixSel,
  input  logic              wBit,
  input  logic              lBit,
  input  logic [1:0]        cpuMode,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              faultOut
);
  shiftCtl_t ctl;

  fshift_ctrl u_ctrl (
    .inValid(inValid), .prefixSel(prefixSel), .wBit(wBit),
    .lBit(lBit), .cpuMode(cpuMode), .ctl(ctl)
  );

  fshift_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .operand(operand),
    .shiftAmt(count[CNT_W-1:0]), .result(result),
    .resultValid(resultValid), .faultOut(faultOut)
  );
endmodule

// File: tb/flagless_shifter_bench.sv
`timescale 1ns/1ps
module flagless_shifter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  prefixSel = 2'b00;
  logic        wBit = 1'b0;
  logic        lBit = 1'b0;
  logic [1:0]  cpuMode = 2'b11;
  logic [63:0] operand = '0;
  logic [63:0] count = '0;
  logic [63:0] result;
  logic        resultValid;
  logic        faultOut;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  flagless_shifter u_flagless_shifter (
    .clk(clk), .rstN(rstN), .inValid(inValid), .prefixSel(prefixSel),
    .wBit(wBit), .lBit(lBit), .cpuMode(cpuMode), .operand(operand),
    .count(count), .result(result), .resultValid(resultValid),
    .faultOut(faultOut)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Behavioural reference: one bit per loop step
  task automatic model(input bit v, input bit [1:0] pf, input bit w, input bit l,
                       input bit [1:0] md, input longint unsigned op, input longint unsigned ct,
                       output bit eV, output bit eF, output longint unsigned eR,
                       output string tag, output bit narrow);
    int size;
    longint unsigned mask, t, sgn;
    int n;
    eV = 0; eF = 0; eR = 0; tag = "R11"; narrow = 0;
    if (!v) return;
    if (l || md < 2 || pf == 0) begin
      eF = 1;
      tag = l ? "R8" : (md < 2 ? "R9" : "R10");
      return;
    end
    eV = 1;
    size = (w && md == 3) ? 64 : 32;
    narrow = (size == 32);
    mask = (size == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    t = op & mask;
    sgn = (t >> (size - 1)) & 1;
    n = int'(ct & longint'(size - 1));
    for (int i = 0; i < n; i++) begin
      case (pf)
        2'b01: t = (t * 2) & mask;
        2'b11: t = t / 2;
        default: t = (t / 2) | (sgn << (size - 1));
      endcase
    end
    eR = t;
    tag = {(size == 64) ? "R2" : "R3", "/R1/",
           (n == 0) ? "R7" : (pf == 2'b10 ? "R5" : "R6")};
  endtask

  task automatic step(input bit v, input bit [1:0] pf, input bit w, input bit l,
                      input bit [1:0] md, input logic [63:0] op, input logic [63:0] ct);
    bit eV, eF, nar;
    longint unsigned eR;
    string tag;
    @(negedge clk);
    inValid = v; prefixSel = pf; wBit = w; lBit = l; cpuMode = md;
    operand = op; count = ct;
    model(v, pf, w, l, md, op, ct, eV, eF, eR, tag, nar);
    @(posedge clk);
    #1;
    check({"R11 valid ", tag}, {63'd0, resultValid}, {63'd0, eV});
    check({"R11 fault ", tag}, {63'd0, faultOut}, {63'd0, eF});
    check({"result ", tag}, result, eR);
    if (nar) check("R4 upper", {32'd0, result[63:32]}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset valid", {63'd0, resultValid}, 64'd0);
    check("R11 reset fault", {63'd0, faultOut}, 64'd0);
    check("R11 reset result", result, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    // R1 R2: wide left shift
    step(1, 2'b01, 1, 0, 2'b11, 64'h0123_4567_89AB_CDEF, 64'd4);
    // R5: sign fill from bit 63
    step(1, 2'b10, 1, 0, 2'b11, 64'h8000_0000_0000_0000, 64'd63);
    // R6: zero fill right
    step(1, 2'b11, 1, 0, 2'b11, 64'h8000_0000_0000_0000, 64'd63);
    // R2: count 67 masked to 3
    step(1, 2'b11, 1, 0, 2'b11, 64'hF000_0000_0000_0000, 64'd67);
    // R3 R4 R5: 32-bit sign fill from bit 31
    step(1, 2'b10, 0, 0, 2'b11, 64'hFFFF_FFFF_8000_0000, 64'd4);
    // R3: W ignored in protected mode, count 33 -> 1
    step(1, 2'b01, 1, 0, 2'b10, 64'hAAAA_AAAA_C000_0001, 64'd33);
    step(1, 2'b10, 1, 0, 2'b10, 64'h0000_0000_8000_0000, 64'd31);
    // R7: zero count, wide and narrow
    step(1, 2'b10, 1, 0, 2'b11, 64'hDEAD_BEEF_0BAD_F00D, 64'd64);
    step(1, 2'b01, 0, 0, 2'b11, 64'hDEAD_BEEF_0BAD_F00D, 64'd32);
    // R8 R9 R10: faults
    step(1, 2'b01, 1, 1, 2'b11, 64'h1, 64'd1);
    step(1, 2'b11, 0, 0, 2'b00, 64'h1, 64'd1);
    step(1, 2'b10, 1, 0, 2'b01, 64'h1, 64'd1);
    step(1, 2'b00, 1, 0, 2'b11, 64'h1, 64'd1);
    // R11: idle cycle
    step(0, 2'b01, 1, 0, 2'b11, 64'h1, 64'd1);
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, 2'($urandom), 1'($urandom),
           ($urandom % 9) == 0, 2'($urandom),
           {$urandom, $urandom}, {$urandom, $urandom});
    end
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule